// File: doc/BRIEF.md
# Transition Count Response Compactor

This block reduces the response of a circuit under test to a single number while a self-test runs. Each valid test cycle it takes the m-bit response word, finds which bits differ from the previous valid word, and adds the number of differing bits to a running total. The total is the signature. Because many streams give the same total, some faulty responses still produce the good total. This aliasing is accepted as the price of storing one counter instead of the whole response.

A test sequence starts with a synchronous `start` pulse, which clears the total and re-arms a first-sample flag. The first valid word after that only seeds the history register. When `testDone` is raised, the block compares the total, including any word taken in that same cycle, with the good-machine total on `goldCount`. It freezes, and holds the outcome on `passFlag` until the next `start`. The counter is sized for `RESP_WIDTH * MAX_SAMPLES` transitions and stops at its all-ones value instead of wrapping.

Top module: `transition_count_compactor`

## Requirements
- R1: While `rstN` is low, and in the cycle after any cycle with `start` high, `countOut` is 0 and `passFlag` is 0.
- R2: The first cycle with `sampleValid` high after a reset or clear only stores the response word. `countOut` does not change.
- R3: Each later cycle with `sampleValid` high adds the number of 1 bits in (`respIn` XOR the previous valid word) to `countOut`, visible after that clock edge. Cycles with `sampleValid` low change neither the count nor the stored word.
- R4: `countOut` saturates at 2^COUNT_WIDTH-1 and never wraps. One step never adds more than RESP_WIDTH.
- R5: In the cycle after `testDone` is high, `passFlag` is 1 when the final count equals `goldCount` and 0 otherwise. A word valid in the same cycle as `testDone` is included in the final count.
- R6: After `testDone`, further valid samples and `testDone` pulses are ignored. `countOut` and `passFlag` hold until `start`.
- R7: `start` takes priority over `sampleValid` and `testDone` in the same cycle. The next valid word is treated as a first word.
- R8: Distinct response streams with equal transition totals give the same count and both pass against that total.
- R9: COUNT_WIDTH equals ceil(log2(RESP_WIDTH*MAX_SAMPLES+1)). The default is 13 bits, with a ceiling of 8191.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Test clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Synchronous clear of count, history and result |
| sampleValid | input | 1 | Qualifies `respIn` this cycle |
| respIn | input | RESP_WIDTH | Primary-output response word |
| testDone | input | 1 | Ends the test and triggers the comparison |
| goldCount | input | COUNT_WIDTH | Expected good-machine transition total |
| countOut | output | COUNT_WIDTH | Accumulated transition count |
| passFlag | output | 1 | Count matched `goldCount` at test end |

## Verification
The properties assume that `rstN` is held low across the first clock edge. They also assume that `start`, `sampleValid` and `testDone` are single-bit values that are never X once reset is released. The bench drives every input on the falling edge from a reset state where all controls are low. It raises `start` for one cycle before each new sequence, so every step bound is measured from a cleared or frozen count. The saturation run feeds more alternating all-ones and all-zeros words than the counter can hold. This drives the count to its ceiling and holds it there.

// File: rtl/tcc_pkg.sv
package tcc_pkg;

  typedef enum logic [1:0] {
    ST_ARM  = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } tccState_e;

  typedef struct packed {
    logic clearAll;
    logic takeSample;
    logic addDelta;
    logic finish;
  } tccStrobes_t;

endpackage

// File: rtl/tcc_control.sv
module tcc_control
  import tcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        sampleValid,
  input  logic        testDone,
  output tccStrobes_t strobes
);

  tccState_e state, stateNext;

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (start) begin
      strobes.clearAll = 1'b1;
      stateNext        = ST_ARM;
    end else begin
      unique case (state)
        ST_ARM: begin
          if (sampleValid) begin
            strobes.takeSample = 1'b1;
            stateNext          = ST_RUN;
          end
          if (testDone) begin
            strobes.finish = 1'b1;
            stateNext      = ST_DONE;
          end
        end
        ST_RUN: begin
          if (sampleValid) begin
            strobes.takeSample = 1'b1;
            strobes.addDelta   = 1'b1;
          end
          if (testDone) begin
            strobes.finish = 1'b1;
            stateNext      = ST_DONE;
          end
        end
        ST_DONE: stateNext = ST_DONE;
        default: stateNext = ST_ARM;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARM;
    else       state <= stateNext;
  end

endmodule

// File: rtl/tcc_datapath.sv
module tcc_datapath
  import tcc_pkg::*;
#(
  parameter int RESP_WIDTH  = 8,
  parameter int COUNT_WIDTH = 13
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  tccStrobes_t            strobes,
  input  logic [RESP_WIDTH-1:0]  respIn,
  input  logic [COUNT_WIDTH-1:0] goldCount,
  output logic [COUNT_WIDTH-1:0] countOut,
  output logic                   passFlag
);

  localparam int DELTA_WIDTH = $clog2(RESP_WIDTH + 1);

  logic [RESP_WIDTH-1:0]  prevWord;
  logic [RESP_WIDTH-1:0]  toggleVec;
  logic [DELTA_WIDTH-1:0] delta;
  logic [COUNT_WIDTH:0]   sumWide;
  logic [COUNT_WIDTH-1:0] countNext;
  logic [COUNT_WIDTH-1:0] countReg;
  logic                   passReg;

  assign toggleVec = respIn ^ prevWord;

  always_comb begin
    delta = '0;
    for (int i = 0; i < RESP_WIDTH; i++) begin
      delta = delta + DELTA_WIDTH'(toggleVec[i]);
    end
  end

  always_comb begin
    sumWide = {1'b0, countReg} + (COUNT_WIDTH + 1)'(delta);
    if (!strobes.addDelta)  countNext = countReg;
    else if (sumWide[COUNT_WIDTH]) countNext = '1;
    else                    countNext = sumWide[COUNT_WIDTH-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      countReg <= '0;
      passReg  <= 1'b0;
    end else if (strobes.clearAll) begin
      prevWord <= '0;
      countReg <= '0;
      passReg  <= 1'b0;
    end else begin
      if (strobes.takeSample) prevWord <= respIn;
      countReg <= countNext;
      if (strobes.finish) passReg <= (countNext == goldCount);
    end
  end

  assign countOut = countReg;
  assign passFlag = passReg;

endmodule

// File: rtl/transition_count_compactor.sv
module transition_count_compactor
  import tcc_pkg::*;
#(
  parameter int RESP_WIDTH  = 8,
  parameter int MAX_SAMPLES = 1000,
  localparam int COUNT_WIDTH = $clog2(RESP_WIDTH * MAX_SAMPLES + 1)
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   start,
  input  logic                   sampleValid,
  input  logic [RESP_WIDTH-1:0]  respIn,
  input  logic                   testDone,
  input  logic [COUNT_WIDTH-1:0] goldCount,
  output logic [COUNT_WIDTH-1:0] countOut,
  output logic                   passFlag
);

  tccStrobes_t strobes;

  tcc_control u_control (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .sampleValid (sampleValid),
    .testDone    (testDone),
    .strobes     (strobes)
  );

  tcc_datapath #(
    .RESP_WIDTH  (RESP_WIDTH),
    .COUNT_WIDTH (COUNT_WIDTH)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .respIn    (respIn),
    .goldCount (goldCount),
    .countOut  (countOut),
    .passFlag  (passFlag)
  );

endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int RESP_WIDTH  = 8,
  parameter int COUNT_WIDTH = 13
) (
  input logic                   clk,
  input logic                   rstN,
  input logic                   start,
  input logic                   testDone,
  input logic [COUNT_WIDTH-1:0] countOut,
  input logic                   passFlag
);

  assert_clear_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (countOut == '0) && !passFlag);

  assert_monotonic_R4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> countOut >= $past(countOut));

  assert_step_bound_R4: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (int'(countOut) - int'($past(countOut))) <= RESP_WIDTH);

  assert_pass_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    (passFlag && !start) |=> passFlag);

  assert_freeze_R6: assert property (@(posedge clk) disable iff (!rstN)
    (passFlag && !start) |=> $stable(countOut));

  assert_no_pass_unfinished_R5: assert property (@(posedge clk) disable iff (!rstN)
    (!passFlag && !testDone) |=> !passFlag);

endmodule

bind transition_count_compactor tcc_checker #(
  .RESP_WIDTH  (RESP_WIDTH),
  .COUNT_WIDTH (COUNT_WIDTH)
) u_checker (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .testDone (testDone),
  .countOut (countOut),
  .passFlag (passFlag)
);

// File: tb/transition_count_compactor_test.sv
module transition_count_compactor_test;

  localparam int RW = 8;
  localparam int NS = 1000;
  localparam int CW = 13;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic          sampleValid = 1'b0;
  logic [RW-1:0] respIn = '0;
  logic          testDone = 1'b0;
  logic [CW-1:0] goldCount = '0;
  logic [CW-1:0] countOut;
  logic          passFlag;

  int checks = 0;
  int fails  = 0;
  bit ended  = 1'b0;

  always #10 clk = ~clk;

  transition_count_compactor #(.RESP_WIDTH(RW), .MAX_SAMPLES(NS)) uut (
    .clk(clk), .rstN(rstN), .start(start), .sampleValid(sampleValid),
    .respIn(respIn), .testDone(testDone), .goldCount(goldCount),
    .countOut(countOut), .passFlag(passFlag)
  );

  // {valid, word} stream and the running count expected after each edge (R2, R3)
  localparam logic [8:0] STIM [10] = '{
    9'h1A5, 9'h15A, 9'h000, 9'h15B, 9'h15B,
    9'h0FF, 9'h1DB, 9'h124, 9'h10F, 9'h1F0
  };
  localparam int EXPC [10] = '{0, 8, 8, 9, 9, 9, 10, 18, 22, 30};

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit v, input logic [RW-1:0] w, input bit d,
                      input bit s, input int gold);
    @(negedge clk);
    sampleValid = v; respIn = w; testDone = d; start = s; goldCount = CW'(gold);
    @(posedge clk);
    #1;
    sampleValid = 1'b0; testDone = 1'b0; start = 1'b0;
  endtask

  task automatic finishRun();
    ended = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset count", int'(countOut), 0);
    check("R1 reset pass", int'(passFlag), 0);
    check("R9 width", $bits(countOut), CW);
    rstN = 1'b1;

    for (int i = 0; i < 10; i++) begin
      step(STIM[i][8], STIM[i][7:0], 1'b0, 1'b0, 0);
      check($sformatf("R3 table step %0d", i), int'(countOut), EXPC[i]);
    end
    check("R5 pass low before done", int'(passFlag), 0);
    step(1'b0, '0, 1'b1, 1'b0, 30);
    check("R5 match pass", int'(passFlag), 1);
    step(1'b1, 8'h0F, 1'b0, 1'b0, 0);
    step(1'b1, 8'hF0, 1'b1, 1'b0, 0);
    check("R6 frozen count", int'(countOut), 30);
    check("R6 pass held", int'(passFlag), 1);

    step(1'b0, '0, 1'b0, 1'b1, 0);
    check("R1 clear count", int'(countOut), 0);
    check("R1 clear pass", int'(passFlag), 0);
    step(1'b1, 8'hFF, 1'b0, 1'b0, 0);
    check("R2 first sample adds none", int'(countOut), 0);
    step(1'b1, 8'hFE, 1'b0, 1'b0, 0);
    check("R3 one toggle", int'(countOut), 1);
    step(1'b0, '0, 1'b1, 1'b0, 2);
    check("R5 mismatch fails", int'(passFlag), 0);
    check("R5 mismatch count", int'(countOut), 1);

    step(1'b0, '0, 1'b0, 1'b1, 0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 0);
    step(1'b1, 8'h03, 1'b1, 1'b0, 2);
    check("R5 same-cycle sample counted", int'(countOut), 2);
    check("R5 same-cycle pass", int'(passFlag), 1);

    step(1'b0, '0, 1'b0, 1'b1, 0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 0);
    step(1'b1, 8'hFF, 1'b0, 1'b1, 0);
    check("R7 start wins over sample", int'(countOut), 0);
    step(1'b1, 8'h0F, 1'b0, 1'b0, 0);
    check("R7 next word is first", int'(countOut), 0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 0);
    check("R7 count after rearm", int'(countOut), 4);

    step(1'b0, '0, 1'b0, 1'b1, 0);
    step(1'b1, 8'h00, 1'b0, 1'b0, 0);
    step(1'b1, 8'hF0, 1'b1, 1'b0, 4);
    check("R8 aliased stream passes", int'(passFlag), 1);

    step(1'b0, '0, 1'b0, 1'b1, 0);
    for (int i = 0; i < 1030; i++) begin
      step(1'b1, (i % 2 == 0) ? 8'h00 : 8'hFF, 1'b0, 1'b0, 0);
    end
    check("R4 saturated", int'(countOut), 8191);
    step(1'b1, 8'h00, 1'b1, 1'b0, 8191);
    check("R4 saturated hold", int'(countOut), 8191);
    check("R4 saturated pass", int'(passFlag), 1);

    finishRun();
  end

endmodule